// File: doc/BRIEF.md
# RC6 Block Encryption Round Engine

This block encrypts one 128-bit block with the RC6 cipher on 32-bit words. A block enters through a valid/ready input together with a 5-bit round count. The engine runs its state machine over the requested number of rounds, from 0 to 31, and then raises a one-cycle done pulse. The ciphertext stays on the output until the next block is accepted.

The expanded key is not stored here. The engine drives a key-table index, and an external synchronous table returns the matching 32-bit word on the following cycle. Each round is split over four clock cycles, so no single cycle chains the squaring multiply, the rotates and the adds.

Back-pressure works as follows. `in_ready` is high only while the engine is idle. A block transfers on a clock edge where `in_valid` and `in_ready` are both high. A sender that sees `in_ready` low must hold its block until `in_ready` returns. Anything presented while `in_ready` is low is not taken. The output side has no back-pressure, because the result is held rather than streamed.

Top module: `rc6_round_engine`

## Requirements
- R1: After reset, `in_ready` is 1, `done` is 0 and `out_block` is all zeros.
- R2: A block is accepted only on an edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the cycle after acceptance until the done cycle. Data and round count presented while `in_ready` is low have no effect on the result.
- R3: The working word A is `in_block[31:0]`, B is `[63:32]`, C is `[95:64]` and D is `[127:96]`. `out_block` uses the same positions for the final A, B, C and D.
- R4: Before the first round, key word 0 is added to B and key word 1 is added to D. With a round count of 0, only this step and the final whitening of R7 are applied.
- R5: Round i (1..r) computes t = rotl(B*(2B+1), 5) and u = rotl(D*(2D+1), 5). It then sets A = rotl(A xor t, u) + key[2i] and C = rotl(C xor u, t) + key[2i+1]. Finally it moves (A,B,C,D) to (B,C,D,A).
- R6: All additions and products wrap modulo 2^32. Every rotate amount is the low 5 bits of its source.
- R7: After the last round, key word 2r+2 is added to A and key word 2r+3 is added to C.
- R8: `key_addr` is a word index into the key table. `key_word` is taken to be the table entry at the index that `key_addr` held one cycle earlier.
- R9: The round count is sampled at acceptance. Later changes of `rounds_in` do not affect the block in flight.
- R10: `done` is high for exactly one cycle, 4r+6 clock edges after the accepting edge. `out_block` then holds its value until the next acceptance.
- R11: `in_ready` is high again in the done cycle, so the next block can be accepted on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input block is valid |
| in_ready | output | 1 | Engine idle, can take a block |
| in_block | input | 128 | Plaintext words {D,C,B,A} |
| rounds_in | input | 5 | Round count for the block being offered |
| key_addr | output | 7 | Expanded-key word index |
| key_word | input | 32 | Key word for the index of the previous cycle |
| done | output | 1 | One-cycle pulse when the result is ready |
| out_block | output | 128 | Ciphertext words {D,C,B,A}, held |

## Verification
The bench sends blocks of all zeros, all ones and mixed patterns at 20 rounds. Uniform words stress the squaring and rotate paths, while mixed words expose swapped word positions or a wrong key index. A round count of 0 isolates the whitening from the rounds. Counts of 1 and 31 separate off-by-one errors in round termination and in the post-whitening index. One block runs while the sender toggles `in_valid` with different data and a changed round count, which separates a correct accept rule from one that latches late inputs. Back-to-back blocks offered in the done cycle test the re-arm timing. The latency and the held output are checked for every block.

// File: rtl/rc6_pkg.sv
package rc6_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE_A,
    ST_PRE_B,
    ST_PRE_D,
    ST_MUL,
    ST_ROT,
    ST_MIX,
    ST_SWAP,
    ST_POST_A,
    ST_POST_B,
    ST_POST_C
  } eng_state_e;
endpackage

// File: rtl/rc6_quad.sv
// Quadratic term x*(2x+1) modulo 2^W.
module rc6_quad #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  logic [W-1:0] odd;
  always_comb begin
    odd = {x[W-2:0], 1'b1};
    y   = x * odd;
  end
endmodule

// File: rtl/rc6_rotl.sv
// Left rotate by a LGW-bit amount.
module rc6_rotl #(
  parameter int W   = 32,
  parameter int LGW = $clog2(W)
) (
  input  logic [W-1:0]   x,
  input  logic [LGW-1:0] amt,
  output logic [W-1:0]   y
);
  logic [2*W-1:0] dbl;
  always_comb begin
    dbl = {x, x} << amt;
    y   = dbl[2*W-1:W];
  end
endmodule

// File: rtl/rc6_ctrl.sv
// Sequencer: round counting, key index generation, handshake and done.
module rc6_ctrl
  import rc6_pkg::*;
#(
  parameter int RW  = 5,
  parameter int KAW = RW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [RW-1:0]  rounds_in,
  output eng_state_e     state,
  output logic [KAW-1:0] key_addr,
  output logic           in_ready,
  output logic           done
);
  logic [RW-1:0] nr;
  logic [RW-1:0] rnd;
  logic [KAW-1:0] rnd_even;
  logic [KAW-1:0] post_base;

  always_comb begin
    rnd_even  = KAW'({rnd, 1'b0});
    post_base = KAW'({nr, 1'b0}) + KAW'(2);
    in_ready  = (state == ST_IDLE);
    unique case (state)
      ST_PRE_B:  key_addr = KAW'(1);
      ST_MUL:    key_addr = rnd_even;
      ST_ROT:    key_addr = rnd_even + KAW'(1);
      ST_POST_A: key_addr = post_base;
      ST_POST_B: key_addr = post_base + KAW'(1);
      default:   key_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      nr    <= '0;
      rnd   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          nr    <= rounds_in;
          state <= ST_PRE_A;
        end
        ST_PRE_A: state <= ST_PRE_B;
        ST_PRE_B: state <= ST_PRE_D;
        ST_PRE_D: begin
          rnd   <= RW'(1);
          state <= (nr == '0) ? ST_POST_A : ST_MUL;
        end
        ST_MUL: state <= ST_ROT;
        ST_ROT: state <= ST_MIX;
        ST_MIX: state <= ST_SWAP;
        ST_SWAP: begin
          if (rnd == nr) state <= ST_POST_A;
          else begin
            rnd   <= rnd + RW'(1);
            state <= ST_MUL;
          end
        end
        ST_POST_A: state <= ST_POST_B;
        ST_POST_B: state <= ST_POST_C;
        ST_POST_C: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rc6_round_engine.sv
// RC6 encryption engine: four working words, multi-cycle rounds.
module rc6_round_engine
  import rc6_pkg::*;
#(
  parameter int W   = 32,
  parameter int RW  = 5,
  localparam int KAW = RW + 2,
  localparam int BLK = 4 * W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [BLK-1:0] in_block,
  input  logic [RW-1:0]  rounds_in,
  output logic [KAW-1:0] key_addr,
  input  logic [W-1:0]   key_word,
  output logic           done,
  output logic [BLK-1:0] out_block
);
  localparam int LGW = $clog2(W);
  localparam int NQ  = 2;
  localparam int NR  = 4;

  eng_state_e state;
  logic       start;
  logic [W-1:0] wa, wb, wc, wd;
  logic [W-1:0] pb, pd, tq, uq, ka;

  logic [W-1:0]   q_in  [NQ];
  logic [W-1:0]   q_out [NQ];
  logic [W-1:0]   r_in  [NR];
  logic [LGW-1:0] r_amt [NR];
  logic [W-1:0]   r_out [NR];

  assign start = in_valid && in_ready;

  rc6_ctrl #(.RW(RW), .KAW(KAW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rounds_in (rounds_in),
    .state     (state),
    .key_addr  (key_addr),
    .in_ready  (in_ready),
    .done      (done)
  );

  always_comb begin
    q_in[0]  = wb;
    q_in[1]  = wd;
    r_in[0]  = wa ^ tq;
    r_amt[0] = uq[LGW-1:0];
    r_in[1]  = wc ^ uq;
    r_amt[1] = tq[LGW-1:0];
    r_in[2]  = pb;
    r_amt[2] = LGW'(LGW);
    r_in[3]  = pd;
    r_amt[3] = LGW'(LGW);
  end

  for (genvar g = 0; g < NQ; g++) begin : g_quad
    rc6_quad #(.W(W)) u_quad (.x(q_in[g]), .y(q_out[g]));
  end

  for (genvar g = 0; g < NR; g++) begin : g_rot
    rc6_rotl #(.W(W), .LGW(LGW)) u_rot (.x(r_in[g]), .amt(r_amt[g]), .y(r_out[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wa <= '0; wb <= '0; wc <= '0; wd <= '0;
      pb <= '0; pd <= '0; tq <= '0; uq <= '0; ka <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          wa <= in_block[W-1:0];
          wb <= in_block[2*W-1:W];
          wc <= in_block[3*W-1:2*W];
          wd <= in_block[4*W-1:3*W];
        end
        ST_PRE_B:  wb <= wb + key_word;
        ST_PRE_D:  wd <= wd + key_word;
        ST_MUL: begin
          pb <= q_out[0];
          pd <= q_out[1];
        end
        ST_ROT: begin
          tq <= r_out[2];
          uq <= r_out[3];
          ka <= key_word;
        end
        ST_MIX: begin
          wa <= r_out[0] + ka;
          wc <= r_out[1] + key_word;
        end
        ST_SWAP: begin
          wa <= wb;
          wb <= wc;
          wc <= wd;
          wd <= wa;
        end
        ST_POST_B: wa <= wa + key_word;
        ST_POST_C: wc <= wc + key_word;
        default: ;
      endcase
    end
  end

  assign out_block = {wd, wc, wb, wa};
endmodule

// File: rtl/rc6_round_engine_chk.sv
module rc6_round_engine_chk #(
  parameter int BLK = 128,
  parameter int KAW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           done,
  input logic [BLK-1:0] out_block
);
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(out_block));

  assert_ready_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!in_ready));
endmodule

bind rc6_round_engine rc6_round_engine_chk #(.BLK(BLK), .KAW(KAW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .done      (done),
  .out_block (out_block)
);

// File: tb/rc6_round_engine_tb.sv
module rc6_round_engine_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_block = '0;
  logic [4:0]   rounds_in = '0;
  logic [6:0]   key_addr;
  logic [31:0]  key_word = '0;
  logic         done;
  logic [127:0] out_block;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic prev_done = 1'b0;
  logic [127:0] last_exp = '0;

  typedef struct {
    logic [127:0] exp;
    int           due;
    int           r;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  rc6_round_engine u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .rounds_in(rounds_in), .key_addr(key_addr),
    .key_word(key_word), .done(done), .out_block(out_block)
  );

  function automatic logic [31:0] kval(int k);
    return (32'hB7E15163 + 32'(k) * 32'h9E3779B9) ^ (32'(k * k) * 32'h01000193);
  endfunction

  // synchronous key table: data follows address by one cycle (R8)
  always @(posedge clk) key_word <= kval(int'(key_addr));
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] rl(logic [31:0] x, logic [4:0] s);
    logic [63:0] d;
    d = {x, x} << s;
    return d[63:32];
  endfunction

  function automatic logic [127:0] ref_enc(logic [127:0] blk, int r);
    logic [31:0] a, b, c, d, t, u, tmp;
    a = blk[31:0]; b = blk[63:32]; c = blk[95:64]; d = blk[127:96];
    b = b + kval(0);
    d = d + kval(1);
    for (int i = 1; i <= r; i++) begin
      tmp = b * ((b << 1) + 32'd1); t = rl(tmp, 5);
      tmp = d * ((d << 1) + 32'd1); u = rl(tmp, 5);
      a = rl(a ^ t, u[4:0]) + kval(2 * i);
      c = rl(c ^ u, t[4:0]) + kval(2 * i + 1);
      tmp = a; a = b; b = c; c = d; d = tmp;
    end
    a = a + kval(2 * r + 2);
    c = c + kval(2 * r + 3);
    return {d, c, b, a};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // driver: offers one block, pushes expectation on acceptance
  task automatic send(input logic [127:0] blk, input int r, input bit junk);
    item_t it;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_block = blk; rounds_in = 5'(r); in_valid = 1'b1;
    @(posedge clk); #1;
    it.exp = ref_enc(blk, r); it.due = cyc + 4 * r + 6; it.r = r;
    sb.push_back(it);
    in_valid = 1'b0;
    if (junk) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(in_ready == 1'b0, "R2 ready low while busy", 128'(in_ready), 128'd0);
        in_valid = 1'b1; in_block = ~blk; rounds_in = 5'(r + 7);
      end
      @(negedge clk);
      in_valid = 1'b0; rounds_in = 5'd17;
    end
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  // monitor: compares results as they appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) chk(1'b0, "R10 done wider than one cycle", 128'd1, 128'd0);
      if (done) begin
        if (sb.size() == 0) chk(1'b0, "R2 unexpected done", 128'd1, 128'd0);
        else begin
          item_t it;
          it = sb.pop_front();
          last_exp = it.exp;
          chk(out_block == it.exp,
              (it.r == 0) ? "R4/R7 whitening-only result" : "R3/R5/R6/R7/R8 ciphertext",
              out_block, it.exp);
          chk(cyc == it.due, "R10 done latency", 128'(cyc), 128'(it.due));
          chk(in_ready == 1'b1, "R11 ready in done cycle", 128'(in_ready), 128'd1);
        end
      end
      prev_done <= done;
    end
  end

  always @(negedge clk) begin
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 reset ready", 128'(in_ready), 128'd1);
    chk(done == 1'b0, "R1 reset done", 128'(done), 128'd0);
    chk(out_block == '0, "R1 reset output", out_block, 128'd0);
    rst_n = 1'b1;

    send('0, 20, 1'b0); drain();
    send('1, 20, 1'b0); drain();
    send(128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0, 0, 1'b0); drain();   // R4
    send(128'h01234567_89abcdef_fedcba98_76543210, 1, 1'b0); drain();
    send(128'hdeadbeef_00000001_80000000_13579bdf, 31, 1'b0); drain();
    repeat (5) @(negedge clk);
    chk(out_block == last_exp, "R10 output held after done", out_block, last_exp);

    send(128'h55aa55aa_33cc33cc_0ff00ff0_a5a5a5a5, 3, 1'b1); drain();   // R2 R9
    repeat (4) @(negedge clk);
    chk(out_block == last_exp, "R2/R9 junk while busy ignored", out_block, last_exp);

    // back-to-back offers (R11): second block waits through the first
    fork
      send(128'h11111111_22222222_33333333_44444444, 2, 1'b0);
    join
    send(128'h99999999_aaaaaaaa_bbbbbbbb_cccccccc, 5, 1'b0);
    drain();
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule